// File: doc/BRIEF.md
# Mode-banked general register file

This block holds the sixteen architectural 32-bit registers of a processor core and maps each one onto physical storage according to the current 5-bit processor mode. Indices 0 to 7 always land on one shared register. Indices 8 to 12 have a private copy for fast-interrupt mode and one copy for every other mode. Indices 13 and 14 have one copy per exception mode plus a copy shared by user and system mode. The core reads two operands per cycle through combinational ports and retires one result per clock edge through a synchronous write port.

Index 15 is the program counter. A read of it returns the current instruction address plus a fixed look-ahead of 8. A write of it stores the value into a dedicated target register after alignment masking. The mask depends on the compact-instruction-state flag. A write-mode override lets the exception-entry logic write into another mode's bank without first switching the current mode.

Top module: `mode_regfile`

## Requirements
- R1: Indices 0 to 7 select one physical register each, and every mode code, valid or not, reads and writes the same copy.
- R2: Indices 8 to 12 select the private copy when the mode is fast interrupt (5'b10001), and the common copy under every other mode code.
- R3: Indices 13 and 14 select one of six copies. User (5'b10000) and system (5'b11111) share one copy. Fast interrupt (5'b10001), IRQ (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) each have their own copy.
- R4: Both read ports are combinational and independent. Each returns the register named by its own index under the current mode.
- R5: Reading index 15 on either port returns `cur_iaddr + 8`, modulo 2^32.
- R6: When `compact_mode` is 1, a write to index 15 stores the data with bit 0 cleared and all other bits kept.
- R7: When `compact_mode` is 0, a write to index 15 stores the data with bits [1:0] cleared and all other bits kept.
- R8: When `wr_ovr_en` is 1, the write selects its bank from `wr_ovr_mode` instead of `mode`. Reads always use `mode`.
- R9: A `mode` code outside the seven listed encodings maps to the user/system bank, and `mode_err` is 1 in that same cycle. For a listed code with no override in use, `mode_err` is 0. An invalid override code on an active write also raises `mode_err`.
- R10: While `rst_n` is 0 at a rising clock edge, every physical register and `pc_q` are cleared to zero.
- R11: A register changes only at a rising edge with `we` high. In the cycle of the write, a read of the same register returns the old value. `pc_q` holds its value unless index 15 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 5 | Current processor mode code |
| compact_mode | input | 1 | 1 when executing compact (halfword) instructions |
| cur_iaddr | input | 32 | Address of the instruction being executed |
| ra_idx | input | 4 | Read port A index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B index |
| rb_data | output | 32 | Read port B data |
| we | input | 1 | Write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| wr_ovr_en | input | 1 | Use `wr_ovr_mode` to pick the write bank |
| wr_ovr_mode | input | 5 | Mode code whose bank the write targets |
| pc_q | output | 32 | Stored program-counter target |
| mode_err | output | 1 | Unrecognised mode code in use this cycle |

## Verification
Some properties are checked on every cycle:
- the look-ahead value on index-15 reads;
- the alignment of `pc_q` after each kind of write;
- `pc_q` holding when index 15 is not written, and clearing on reset;
- the `mode_err` flag against the mode code;
- shared low registers staying steady across mode changes.

The full mode-to-copy map needs the bench. It writes every index in every mode with a distinct value and reads everything back under every mode, so that one copy aliasing another shows up. The same holds for override writes landing in the foreign bank, and for the old value being read in the cycle of the write.

// File: rtl/rb_pkg.sv
// Shared constants and types for the mode-banked register file.
// Assumes a 5-bit mode code and 16 architectural registers.
package rb_pkg;
    localparam int IDX_W    = 4;
    localparam int MODE_W   = 5;
    localparam int N_SHARED = 8;  // indices with a single copy
    localparam int N_HI     = 5;  // indices with a fast-interrupt copy
    localparam int N_BANKS  = 6;  // copies of the two top indices
    localparam int N_SPLR   = 2;  // number of fully banked indices
    localparam int BANK_W   = $clog2(N_BANKS);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    typedef logic [BANK_W-1:0] bank_t;

    localparam bank_t BANK_USR = 3'd0;
    localparam bank_t BANK_FIQ = 3'd1;
    localparam bank_t BANK_IRQ = 3'd2;
    localparam bank_t BANK_SVC = 3'd3;
    localparam bank_t BANK_ABT = 3'd4;
    localparam bank_t BANK_UND = 3'd5;
endpackage

// File: rtl/rb_mode_decode.sv
// Maps a mode code onto a bank number and flags unknown codes.
// Assumes unknown codes must fall back to the user/system bank.
module rb_mode_decode
    import rb_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_t             bank_o,
    output logic              is_fiq_o,
    output logic              valid_o
);
    // Purpose: translate the mode code to a bank and validity flag.
    always_comb begin
        valid_o = 1'b1;
        bank_o  = BANK_USR;
        case (mode_i)
            MODE_USR, MODE_SYS: bank_o = BANK_USR;
            MODE_FIQ:           bank_o = BANK_FIQ;
            MODE_IRQ:           bank_o = BANK_IRQ;
            MODE_SVC:           bank_o = BANK_SVC;
            MODE_ABT:           bank_o = BANK_ABT;
            MODE_UND:           bank_o = BANK_UND;
            default:            valid_o = 1'b0;
        endcase
    end

    assign is_fiq_o = (bank_o == BANK_FIQ);
endmodule

// File: rtl/rb_pc_unit.sv
// Holds the program-counter target and forms its look-ahead read value.
// Assumes the write mask depends only on the compact-state flag.
module rb_pc_unit #(
    parameter int XLEN     = 32,
    parameter int PC_AHEAD = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            compact_i,
    input  logic [XLEN-1:0] iaddr_i,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_data_i,
    output logic [XLEN-1:0] pc_q_o,
    output logic [XLEN-1:0] pc_rd_o
);
    localparam logic [XLEN-1:0] MASK_WIDE    = ~(XLEN'(3));
    localparam logic [XLEN-1:0] MASK_COMPACT = ~(XLEN'(1));

    logic [XLEN-1:0] wr_mask;

    // Purpose: choose the alignment mask for the current instruction state.
    always_comb begin
        wr_mask = compact_i ? MASK_COMPACT : MASK_WIDE;
    end

    // Purpose: store the masked target on a write to index 15.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q_o <= '0;
        end else if (wr_en_i) begin
            pc_q_o <= wr_data_i & wr_mask;
        end
    end

    assign pc_rd_o = iaddr_i + XLEN'(PC_AHEAD);
endmodule

// File: rtl/rb_bank_store.sv
// Physical storage for indices 0..14 with mode banking.
// Assumes the index decode happens upstream: 15 never reaches here.
module rb_bank_store
    import rb_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NSHARED = N_SHARED,
    parameter int NHI     = N_HI,
    parameter int NBANKS  = N_BANKS,
    parameter int NSPLR   = N_SPLR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_fiq_i,
    input  bank_t            wr_bank_i,
    input  logic [XLEN-1:0]  wr_data_i,
    input  logic             rd_fiq_i,
    input  bank_t            rd_bank_i,
    input  logic [IDX_W-1:0] ra_idx_i,
    input  logic [IDX_W-1:0] rb_idx_i,
    output logic [XLEN-1:0]  ra_data_o,
    output logic [XLEN-1:0]  rb_data_o
);
    localparam int HI_BASE   = NSHARED;
    localparam int SPLR_BASE = NSHARED + NHI;
    localparam int SH_W      = $clog2(NSHARED);
    localparam int HI_W      = $clog2(NHI);
    localparam int SP_W      = (NSPLR > 1) ? $clog2(NSPLR) : 1;

    logic [XLEN-1:0] shared_q [NSHARED];
    logic [XLEN-1:0] hi_q     [2][NHI];
    logic [XLEN-1:0] splr_q   [NBANKS][NSPLR];

    // Shared low registers, one copy each.
    for (genvar g = 0; g < NSHARED; g++) begin : g_shared
        logic [XLEN-1:0] q;
        // Purpose: update one shared register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
                q <= wr_data_i;
            end
        end
        assign shared_q[g] = q;
    end

    // Middle registers: copy 0 common, copy 1 fast-interrupt only.
    for (genvar c = 0; c < 2; c++) begin : g_hi_copy
        for (genvar g = 0; g < NHI; g++) begin : g_hi
            logic [XLEN-1:0] q;
            // Purpose: update one middle register of this copy.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en_i && wr_idx_i == IDX_W'(HI_BASE + g)
                             && (wr_fiq_i == (c == 1))) begin
                    q <= wr_data_i;
                end
            end
            assign hi_q[c][g] = q;
        end
    end

    // Top registers: one copy per bank.
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        for (genvar g = 0; g < NSPLR; g++) begin : g_splr
            logic [XLEN-1:0] q;
            // Purpose: update one fully banked register of this bank.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en_i && wr_idx_i == IDX_W'(SPLR_BASE + g)
                             && wr_bank_i == BANK_W'(b)) begin
                    q <= wr_data_i;
                end
            end
            assign splr_q[b][g] = q;
        end
    end

    function automatic logic [XLEN-1:0] pick(input logic [IDX_W-1:0] idx);
        logic [XLEN-1:0] v;
        if (int'(idx) < HI_BASE) begin
            v = shared_q[SH_W'(idx)];
        end else if (int'(idx) < SPLR_BASE) begin
            v = hi_q[rd_fiq_i][HI_W'(idx - IDX_W'(HI_BASE))];
        end else begin
            v = splr_q[rd_bank_i][SP_W'(idx - IDX_W'(SPLR_BASE))];
        end
        return v;
    endfunction

    // Purpose: read port A mux.
    always_comb begin
        ra_data_o = pick(ra_idx_i);
    end

    // Purpose: read port B mux.
    always_comb begin
        rb_data_o = pick(rb_idx_i);
    end
endmodule

// File: rtl/mode_regfile.sv
// Top of the mode-banked register file: two reads, one write, index 15
// routed to the program-counter unit. Assumes reads follow `mode` and
// writes follow the override mode when enabled.
module mode_regfile
    import rb_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int PC_AHEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              compact_mode,
    input  logic [XLEN-1:0]   cur_iaddr,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [XLEN-1:0]   ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [XLEN-1:0]   rb_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              wr_ovr_en,
    input  logic [MODE_W-1:0] wr_ovr_mode,
    output logic [XLEN-1:0]   pc_q,
    output logic              mode_err
);
    localparam logic [IDX_W-1:0] PC_IDX = '1;

    bank_t             rd_bank, wr_bank;
    logic              rd_fiq, wr_fiq, rd_valid, wr_valid;
    logic [MODE_W-1:0] wr_mode;
    logic [XLEN-1:0]   st_a, st_b, pc_rd;
    logic              gpr_we, pc_we;

    assign wr_mode = wr_ovr_en ? wr_ovr_mode : mode;
    assign gpr_we  = we && (wr_idx != PC_IDX);
    assign pc_we   = we && (wr_idx == PC_IDX);

    rb_mode_decode u_rd_dec (
        .mode_i   (mode),
        .bank_o   (rd_bank),
        .is_fiq_o (rd_fiq),
        .valid_o  (rd_valid)
    );

    rb_mode_decode u_wr_dec (
        .mode_i   (wr_mode),
        .bank_o   (wr_bank),
        .is_fiq_o (wr_fiq),
        .valid_o  (wr_valid)
    );

    rb_bank_store #(.XLEN(XLEN)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (gpr_we),
        .wr_idx_i  (wr_idx),
        .wr_fiq_i  (wr_fiq),
        .wr_bank_i (wr_bank),
        .wr_data_i (wr_data),
        .rd_fiq_i  (rd_fiq),
        .rd_bank_i (rd_bank),
        .ra_idx_i  (ra_idx),
        .rb_idx_i  (rb_idx),
        .ra_data_o (st_a),
        .rb_data_o (st_b)
    );

    rb_pc_unit #(.XLEN(XLEN), .PC_AHEAD(PC_AHEAD)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .compact_i (compact_mode),
        .iaddr_i   (cur_iaddr),
        .wr_en_i   (pc_we),
        .wr_data_i (wr_data),
        .pc_q_o    (pc_q),
        .pc_rd_o   (pc_rd)
    );

    // Purpose: steer index 15 reads to the look-ahead value.
    always_comb begin
        ra_data = (ra_idx == PC_IDX) ? pc_rd : st_a;
        rb_data = (rb_idx == PC_IDX) ? pc_rd : st_b;
    end

    // Purpose: flag an unknown code on the read mode or an active override.
    always_comb begin
        mode_err = !rd_valid || (we && wr_ovr_en && !wr_valid);
    end
endmodule

// File: rtl/rb_checker.sv
// Cycle-level properties of the register file, bound to its top.
module rb_checker #(
    parameter int XLEN     = 32,
    parameter int PC_AHEAD = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      mode,
    input logic            compact_mode,
    input logic [XLEN-1:0] cur_iaddr,
    input logic [3:0]      ra_idx,
    input logic [XLEN-1:0] ra_data,
    input logic [3:0]      rb_idx,
    input logic [XLEN-1:0] rb_data,
    input logic            we,
    input logic [3:0]      wr_idx,
    input logic [XLEN-1:0] wr_data,
    input logic            wr_ovr_en,
    input logic [4:0]      wr_ovr_mode,
    input logic [XLEN-1:0] pc_q,
    input logic            mode_err
);
    AST_PC_LOOKAHEAD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx == 4'hF) |-> (ra_data == cur_iaddr + XLEN'(PC_AHEAD))); // R5
    AST_PC_LOOKAHEAD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_idx == 4'hF) |-> (rb_data == cur_iaddr + XLEN'(PC_AHEAD))); // R5
    AST_PC_COMPACT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx == 4'hF && compact_mode)
        |=> (pc_q[0] == 1'b0 && pc_q[XLEN-1:1] == $past(wr_data[XLEN-1:1]))); // R6
    AST_PC_WIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx == 4'hF && !compact_mode)
        |=> (pc_q[1:0] == 2'b00 && pc_q[XLEN-1:2] == $past(wr_data[XLEN-1:2]))); // R7
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && wr_idx == 4'hF) |=> $stable(pc_q)); // R11
    AST_PC_RESET: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0)); // R10
    AST_BAD_MODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                       5'b10111, 5'b11011, 5'b11111}) |-> mode_err); // R9
    AST_GOOD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                       5'b10111, 5'b11011, 5'b11111}) && !(we && wr_ovr_en))
        |-> !mode_err); // R9
    AST_LOW_SHARED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx < 4'd8 && $stable(ra_idx) && !$past(we)) |-> $stable(ra_data)); // R1
endmodule

bind mode_regfile rb_checker #(.XLEN(XLEN), .PC_AHEAD(PC_AHEAD)) u_chk (.*);

// File: tb/sim_mode_regfile.sv
module sim_mode_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b10000;
    logic        compact_mode = 1'b0;
    logic [31:0] cur_iaddr = '0;
    logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic [31:0] ra_data, rb_data, wr_data = '0, pc_q;
    logic        we = 1'b0, wr_ovr_en = 1'b0, mode_err;
    logic [4:0]  wr_ovr_mode = 5'b10000;

    int n_vec = 0, n_bad = 0, seq = 0;
    bit done = 0;
    logic [31:0] mdl [30];

    localparam logic [4:0] MODES [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                         5'b10111, 5'b11011, 5'b11111, 5'b00110};

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_regfile u0 (.*);

    function automatic int slot(input logic [4:0] m, input int idx);
        int b;
        case (m)
            5'b10001: b = 1;
            5'b10010: b = 2;
            5'b10011: b = 3;
            5'b10111: b = 4;
            5'b11011: b = 5;
            default:  b = 0;
        endcase
        if (idx < 8) return idx;
        if (idx < 13) return (b == 1) ? 13 + idx - 8 : idx;
        return 18 + b * 2 + idx - 13;
    endfunction

    function automatic string tag_of(input int i, input int mi);
        if (mi == 7) return "R9";
        if (i < 8) return "R1";
        if (i < 13) return "R2";
        return "R3";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic do_write(input int idx, input logic [31:0] d,
                            input logic ovr, input logic [4:0] om);
        @(negedge clk);
        we = 1'b1; wr_idx = 4'(idx); wr_data = d;
        wr_ovr_en = ovr; wr_ovr_mode = om;
        @(negedge clk);
        we = 1'b0; wr_ovr_en = 1'b0;
        if (idx < 15) mdl[slot(ovr ? om : mode, idx)] = d;
    endtask

    // R4: both ports read independently under each mode
    task automatic read_all();
        for (int mi = 0; mi < 8; mi++) begin
            for (int i = 0; i < 15; i++) begin
                mode = MODES[mi]; ra_idx = 4'(i); rb_idx = 4'(14 - i);
                #1;
                chk(tag_of(i, mi), ra_data, mdl[slot(MODES[mi], i)]);
                chk("R4", rb_data, mdl[slot(MODES[mi], 14 - i)]);
                if (i == 0) chk("R9", 32'(mode_err), 32'(mi == 7));
            end
        end
        mode = 5'b10000;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        for (int s = 0; s < 30; s++) mdl[s] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        read_all();
        chk("R10", pc_q, 32'h0);
        rst_n = 1'b1;

        // R1 R2 R3: write every index in every mode code, then read all back
        for (int mi = 0; mi < 8; mi++) begin
            mode = MODES[mi];
            for (int i = 0; i < 15; i++) begin
                seq++;
                do_write(i, {8'(mi), 8'(i), 16'(seq * 16'h1F3)}, 1'b0, 5'b10000);
            end
            read_all();
        end

        // R8: override writes land in the named bank, not the current one
        mode = 5'b10000;
        do_write(13, 32'hC0DE0013, 1'b1, 5'b10010);
        do_write(14, 32'hC0DE0014, 1'b1, 5'b10011);
        do_write(9,  32'hC0DE0009, 1'b1, 5'b10001);
        do_write(10, 32'hC0DE000A, 1'b1, 5'b11011);
        mode = 5'b10000; ra_idx = 4'd13; #1;
        chk("R8", ra_data, mdl[slot(5'b10000, 13)]);
        read_all();

        // R5: look-ahead read on both ports
        for (int k = 0; k < 64; k++) begin
            cur_iaddr = 32'(k) * 32'h0400_0104 + 32'h10;
            ra_idx = 4'hF; rb_idx = 4'hF; #1;
            chk("R5", ra_data, cur_iaddr + 32'd8);
            chk("R5", rb_data, cur_iaddr + 32'd8);
        end
        cur_iaddr = 32'hFFFF_FFF8; #1;
        chk("R5", ra_data, 32'h0);

        // R7: wide state clears two low bits
        compact_mode = 1'b0;
        do_write(15, 32'h0000_1003, 1'b0, 5'b10000);
        chk("R7", pc_q, 32'h0000_1000);
        do_write(15, 32'hFFFF_FFFE, 1'b0, 5'b10000);
        chk("R7", pc_q, 32'hFFFF_FFFC);
        // R6: compact state clears bit 0 only
        compact_mode = 1'b1;
        do_write(15, 32'h0000_1003, 1'b0, 5'b10000);
        chk("R6", pc_q, 32'h0000_1002);
        do_write(15, 32'hABCD_0001, 1'b0, 5'b10000);
        chk("R6", pc_q, 32'hABCD_0000);
        compact_mode = 1'b0;

        // R11: old value visible in the write cycle, new after the edge
        mode = 5'b10000;
        @(negedge clk);
        we = 1'b1; wr_idx = 4'd5; wr_data = 32'h5555_AAAA; ra_idx = 4'd5;
        #1;
        chk("R11", ra_data, mdl[5]);
        @(posedge clk); #1;
        we = 1'b0;
        mdl[5] = 32'h5555_AAAA;
        chk("R11", ra_data, 32'h5555_AAAA);
        // R11: data without enable has no effect, pc_q holds
        @(negedge clk);
        wr_idx = 4'd6; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        ra_idx = 4'd6; #1;
        chk("R11", ra_data, mdl[6]);
        chk("R11", pc_q, 32'hABCD_0000);

        // R9: override with unknown code raises the flag during the write
        @(negedge clk);
        we = 1'b1; wr_idx = 4'd13; wr_data = 32'h1313_1313;
        wr_ovr_en = 1'b1; wr_ovr_mode = 5'b00001; #1;
        chk("R9", 32'(mode_err), 32'd1);
        @(negedge clk);
        we = 1'b0; wr_ovr_en = 1'b0;
        mdl[slot(5'b00001, 13)] = 32'h1313_1313;
        read_all();

        // R10: mid-run reset clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int s = 0; s < 30; s++) mdl[s] = '0;
        read_all();
        chk("R10", pc_q, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        report();
    end
endmodule